// File: doc/BRIEF.md
# Four-Channel Host-to-Controller Mailbox

This block is a set of four byte-wide mailboxes between a host-facing port and the word-wide register bus of a management controller. Each channel has an inbound data word that the host fills, an outbound data word that the controller fills, and a status word. The status word holds two full flags, one for each direction. A flag is raised by a write from one side and dropped by a read from the other side, so each side can tell when its partner has consumed a byte.

The controller side also holds the control words. These switch each channel on and gate an interrupt that fires when inbound data arrives. The block drives one interrupt line per channel and a combined line. The controller reaches everything through a 4 KiB byte-addressed window of aligned 32-bit words with byte enables. Words past the implemented array read as zero and drop writes. Words in the array that carry no special meaning act as plain storage.

Top module: `kcs_mailbox`

## Requirements
- R1: While reset is active and after it ends, every word reads zero, except the word at byte offset 0x88, which holds the value on `ctl7_init`. All interrupt outputs are low.
- R2: A controller write updates only the bytes whose `mgmt_be` bit is set. A controller read returns its word one cycle after the request, with `mgmt_rvalid` high for that one cycle.
- R3: A controller address whose word index is `NUM_WORDS` or more reads as zero, and a write to it changes no stored word.
- R4: A host data write to channel c stores the byte in the low byte of that channel's inbound word and sets bit 1 (inbound full) of its status word. The inbound words sit at 0x24, 0x28, 0x2C and 0x114; the status words sit at 0x3C, 0x40, 0x44 and 0x11C.
- R5: A controller read of an inbound word returns the stored byte and clears the inbound-full flag. If that flag was set, the read also drops the channel's interrupt line.
- R6: A host data write raises `chan_irq[c]` only when the channel is on and its interrupt enable is set. Channel enables: word 0x00 bits 5 and 6 for channels 0 and 1, word 0x100 bit 0 for channel 3. Interrupt enables: word 0x08 bits 1, 2 and 3 for channels 0 to 2, word 0x100 bit 1 for channel 3.
- R7: Channel 2 is on only while both word 0x00 bit 7 and word 0x10 bit 2 are set.
- R8: A controller write to an outbound word (0x30, 0x34, 0x38, 0x118) sets status bit 0 (outbound full). A host data read returns the low byte of the outbound word one cycle later, with `host_rvalid` high, and clears that flag.
- R9: A host write with `host_sel_status` set changes nothing. A host status read returns the low byte of the channel's status word, and status bit 3 is kept as the controller wrote it.
- R10: `irq_any` is high exactly while at least one `chan_irq` line is high (with the default combinational option).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl7_init | input | 32 | Value loaded into word 0x88 at reset |
| mgmt_req | input | 1 | Controller access request |
| mgmt_we | input | 1 | Controller access is a write |
| mgmt_addr | input | ADDR_W | Controller byte address, word aligned |
| mgmt_be | input | 4 | Controller byte enables |
| mgmt_wdata | input | 32 | Controller write data |
| mgmt_rdata | output | 32 | Controller read data |
| mgmt_rvalid | output | 1 | Controller read data valid |
| host_req | input | 1 | Host access request |
| host_we | input | 1 | Host access is a write |
| host_sel_status | input | 1 | Host access targets the status word rather than data |
| host_chan | input | 2 | Host channel select |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_rvalid | output | 1 | Host read data valid |
| chan_irq | output | 4 | Per-channel inbound interrupt lines |
| irq_any | output | 1 | OR of all channel interrupt lines |

## Verification
The bench builds the block with its default parameters: 72 implemented words, a 12-bit address and a combinational combined interrupt. With 72 words, every channel word is inside the array. Offsets from 0x120 to the top of the window are outside it, and an address of 0x200 wraps to index 0 in the truncated index, which tests whether the range guard really blocks the write. With the combinational option, `irq_any` can be checked in the same cycle as the per-channel lines. The stimulus covers channel 2 with only one of its two enables set, and channel 3 with its interrupt enable set while the channel is off.

// File: rtl/kcs_pkg.sv
package kcs_pkg;
   localparam int unsigned W_CTL0 = 0;
   localparam int unsigned W_CTL2 = 2;
   localparam int unsigned W_CTL4 = 4;
   localparam int unsigned W_CTL7 = 34;
   localparam int unsigned W_CTLB = 64;
   localparam int unsigned ST_OBF = 0;
   localparam int unsigned ST_IBF = 1;
   localparam int unsigned ST_CD  = 3;

   function automatic int unsigned idr_word(input int ch);
      return (ch < 3) ? 9 + ch : 69;
   endfunction

   function automatic int unsigned odr_word(input int ch);
      return (ch < 3) ? 12 + ch : 70;
   endfunction

   function automatic int unsigned str_word(input int ch);
      return (ch < 3) ? 15 + ch : 71;
   endfunction

   // channel switched on; channel 2 needs two bits
   function automatic logic chan_live(input int ch, input logic [31:0] c0,
                                      input logic [31:0] c4, input logic [31:0] cb);
      case (ch)
         0:       return c0[5];
         1:       return c0[6];
         2:       return c0[7] & c4[2];
         default: return cb[0];
      endcase
   endfunction

   function automatic logic irq_allow(input int ch, input logic [31:0] c2,
                                      input logic [31:0] cb);
      case (ch)
         0:       return c2[1];
         1:       return c2[2];
         2:       return c2[3];
         default: return cb[1];
      endcase
   endfunction
endpackage

// File: rtl/kcs_regfile.sv
module kcs_regfile #(
   parameter int unsigned NUM_WORDS = 72,
   parameter int unsigned INIT_IDX  = 34,
   localparam int unsigned IDX_W    = $clog2(NUM_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      init_word,
   input  logic             m_we,
   input  logic [IDX_W-1:0] m_idx,
   input  logic [3:0]       m_be,
   input  logic [31:0]      m_wdata,
   input  logic             h_we,
   input  logic [IDX_W-1:0] h_idx,
   input  logic [7:0]       h_byte,
   output logic [31:0]      words [NUM_WORDS]
);
   for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            words[w] <= (w == INIT_IDX) ? init_word : 32'd0;
         end else begin
            for (int b = 0; b < 4; b++) begin
               if (m_we && m_idx == IDX_W'(w) && m_be[b])
                  words[w][8*b +: 8] <= m_wdata[8*b +: 8];
            end
            if (h_we && h_idx == IDX_W'(w))
               words[w][7:0] <= h_byte;
         end
      end
   end
endmodule

// File: rtl/kcs_chan.sv
module kcs_chan (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       irq_arm,
   input  logic       str_wr,
   input  logic [1:0] str_wbits,
   input  logic       ibf_set,
   input  logic       ibf_clr,
   input  logic       obf_set,
   input  logic       obf_clr,
   output logic       ibf,
   output logic       obf,
   output logic       irq
);
   logic ibf_n, obf_n;

   always_comb begin
      ibf_n = str_wr ? str_wbits[1] : ibf;
      obf_n = str_wr ? str_wbits[0] : obf;
      if (ibf_clr) ibf_n = 1'b0;
      if (obf_clr) obf_n = 1'b0;
      if (ibf_set) ibf_n = 1'b1;
      if (obf_set) obf_n = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ibf <= 1'b0;
         obf <= 1'b0;
         irq <= 1'b0;
      end else begin
         ibf <= ibf_n;
         obf <= obf_n;
         if (ibf_set && irq_arm)  irq <= 1'b1;
         else if (ibf_clr && ibf) irq <= 1'b0;
      end
   end
endmodule

// File: rtl/kcs_mailbox.sv
module kcs_mailbox #(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned NUM_WORDS   = 72,
   parameter int unsigned NUM_CHAN    = 4,
   parameter bit          IRQ_ANY_REG = 1'b0,
   localparam int unsigned IDX_W      = $clog2(NUM_WORDS),
   localparam int unsigned CHAN_W     = $clog2(NUM_CHAN)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [31:0]         ctl7_init,
   input  logic                mgmt_req,
   input  logic                mgmt_we,
   input  logic [ADDR_W-1:0]   mgmt_addr,
   input  logic [3:0]          mgmt_be,
   input  logic [31:0]         mgmt_wdata,
   output logic [31:0]         mgmt_rdata,
   output logic                mgmt_rvalid,
   input  logic                host_req,
   input  logic                host_we,
   input  logic                host_sel_status,
   input  logic [CHAN_W-1:0]   host_chan,
   input  logic [7:0]          host_wdata,
   output logic [7:0]          host_rdata,
   output logic                host_rvalid,
   output logic [NUM_CHAN-1:0] chan_irq,
   output logic                irq_any
);
   if (NUM_CHAN != 4) begin : g_bad_chan
      $error("kcs_mailbox: NUM_CHAN must be 4");
   end
   if (NUM_WORDS <= kcs_pkg::str_word(3)) begin : g_bad_words
      $error("kcs_mailbox: NUM_WORDS too small for channel words");
   end
   if (NUM_WORDS * 4 > (1 << ADDR_W) || IDX_W + 2 > ADDR_W) begin : g_bad_addr
      $error("kcs_mailbox: window too small for NUM_WORDS");
   end

   logic [31:0]      words [NUM_WORDS];
   logic [31:0]      view  [NUM_WORDS];
   logic             in_range, mwr, mrd;
   logic [IDX_W-1:0] m_idx, h_idx, h_st_idx, h_od_idx;
   logic             h_data_wr;
   logic [NUM_CHAN-1:0] ibf, obf;

   assign in_range  = 32'(mgmt_addr[ADDR_W-1:2]) < NUM_WORDS;
   assign m_idx     = mgmt_addr[IDX_W+1:2];
   assign mwr       = mgmt_req & mgmt_we & in_range;
   assign mrd       = mgmt_req & ~mgmt_we & in_range;
   assign h_data_wr = host_req & host_we & ~host_sel_status;
   assign h_idx     = IDX_W'(kcs_pkg::idr_word(int'(host_chan)));
   assign h_od_idx  = IDX_W'(kcs_pkg::odr_word(int'(host_chan)));
   assign h_st_idx  = IDX_W'(kcs_pkg::str_word(int'(host_chan)));

   kcs_regfile #(.NUM_WORDS(NUM_WORDS), .INIT_IDX(kcs_pkg::W_CTL7)) u_regs (
      .clk(clk), .rst_n(rst_n), .init_word(ctl7_init),
      .m_we(mwr), .m_idx(m_idx), .m_be(mgmt_be), .m_wdata(mgmt_wdata),
      .h_we(h_data_wr), .h_idx(h_idx), .h_byte(host_wdata),
      .words(words)
   );

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      localparam int unsigned IW = kcs_pkg::idr_word(c);
      localparam int unsigned OW = kcs_pkg::odr_word(c);
      localparam int unsigned SW = kcs_pkg::str_word(c);
      logic hit, arm;
      assign hit = host_req && host_chan == CHAN_W'(c);
      assign arm = kcs_pkg::chan_live(c, words[kcs_pkg::W_CTL0], words[kcs_pkg::W_CTL4],
                                      words[kcs_pkg::W_CTLB])
                 & kcs_pkg::irq_allow(c, words[kcs_pkg::W_CTL2], words[kcs_pkg::W_CTLB]);
      kcs_chan u_chan (
         .clk(clk), .rst_n(rst_n), .irq_arm(arm),
         .str_wr(mwr && m_idx == IDX_W'(SW) && mgmt_be[0]),
         .str_wbits(mgmt_wdata[1:0]),
         .ibf_set(hit & host_we & ~host_sel_status),
         .ibf_clr(mrd && m_idx == IDX_W'(IW)),
         .obf_set(mwr && m_idx == IDX_W'(OW)),
         .obf_clr(hit & ~host_we & ~host_sel_status),
         .ibf(ibf[c]), .obf(obf[c]), .irq(chan_irq[c])
      );
   end

   always_comb begin
      for (int w = 0; w < NUM_WORDS; w++) view[w] = words[w];
      for (int c = 0; c < NUM_CHAN; c++) begin
         view[kcs_pkg::str_word(c)][kcs_pkg::ST_IBF] = ibf[c];
         view[kcs_pkg::str_word(c)][kcs_pkg::ST_OBF] = obf[c];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mgmt_rdata  <= '0;
         mgmt_rvalid <= 1'b0;
         host_rdata  <= '0;
         host_rvalid <= 1'b0;
      end else begin
         mgmt_rvalid <= mgmt_req & ~mgmt_we;
         if (mgmt_req && !mgmt_we) mgmt_rdata <= in_range ? view[m_idx] : 32'd0;
         host_rvalid <= host_req & ~host_we;
         if (host_req && !host_we)
            host_rdata <= host_sel_status ? view[h_st_idx][7:0] : words[h_od_idx][7:0];
      end
   end

   if (IRQ_ANY_REG) begin : g_any_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_any <= 1'b0;
         else        irq_any <= |chan_irq;
      end
   end else begin : g_any_comb
      assign irq_any = |chan_irq;
   end
endmodule

// File: rtl/kcs_mailbox_chk.sv
module kcs_mailbox_chk #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned NUM_WORDS = 72,
   parameter int unsigned NUM_CHAN  = 4,
   localparam int unsigned CHAN_W   = $clog2(NUM_CHAN)
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mgmt_req,
   input logic                mgmt_we,
   input logic [ADDR_W-1:0]   mgmt_addr,
   input logic [31:0]         mgmt_rdata,
   input logic                mgmt_rvalid,
   input logic                host_req,
   input logic                host_we,
   input logic                host_sel_status,
   input logic [CHAN_W-1:0]   host_chan,
   input logic                host_rvalid,
   input logic [NUM_CHAN-1:0] chan_irq
);
   // R2
   mgmt_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_req && !mgmt_we) |=> mgmt_rvalid);

   // R3
   oob_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mgmt_req && !mgmt_we && 32'(mgmt_addr[ADDR_W-1:2]) >= NUM_WORDS) |=> mgmt_rdata == 32'd0);

   // R8
   host_read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && !host_we) |=> host_rvalid);

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_ch
      localparam logic [ADDR_W-1:0] IDR_A = ADDR_W'(kcs_pkg::idr_word(c) * 4);
      // R6
      irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(chan_irq[c]) |-> $past(host_req && host_we && !host_sel_status
                                      && host_chan == CHAN_W'(c)));
      // R5
      irq_fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(chan_irq[c]) |-> $past(mgmt_req && !mgmt_we && mgmt_addr == IDR_A));
   end
endmodule

bind kcs_mailbox kcs_mailbox_chk #(.ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .NUM_CHAN(NUM_CHAN))
   u_chk (.*);

// File: tb/tb_kcs_mailbox.sv
module tb_kcs_mailbox;
   localparam time CLK_PERIOD = 10ns;
   localparam logic [31:0] INIT7 = 32'h1234_5678;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mgmt_req = 0, mgmt_we = 0;
   logic [11:0] mgmt_addr = '0;
   logic [3:0]  mgmt_be = '0;
   logic [31:0] mgmt_wdata = '0, mgmt_rdata;
   logic        mgmt_rvalid;
   logic        host_req = 0, host_we = 0, host_sel_status = 0;
   logic [1:0]  host_chan = '0;
   logic [7:0]  host_wdata = '0, host_rdata;
   logic        host_rvalid;
   logic [3:0]  chan_irq;
   logic        irq_any;

   int checks = 0, errors = 0;
   bit finished = 0;
   logic [31:0] m_exp_q[$];
   string       m_tag_q[$];
   logic [7:0]  h_exp_q[$];
   string       h_tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   kcs_mailbox dut (
      .clk(clk), .rst_n(rst_n), .ctl7_init(INIT7),
      .mgmt_req(mgmt_req), .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr), .mgmt_be(mgmt_be),
      .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata), .mgmt_rvalid(mgmt_rvalid),
      .host_req(host_req), .host_we(host_we), .host_sel_status(host_sel_status),
      .host_chan(host_chan), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .chan_irq(chan_irq), .irq_any(irq_any)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops expected items as read data appears
   always @(negedge clk) begin
      if (rst_n && mgmt_rvalid) begin
         if (m_exp_q.size() == 0) check("R2 unexpected mgmt_rvalid", 32'd1, 32'd0);
         else check(m_tag_q.pop_front(), mgmt_rdata, m_exp_q.pop_front());
      end
      if (rst_n && host_rvalid) begin
         if (h_exp_q.size() == 0) check("R8 unexpected host_rvalid", 32'd1, 32'd0);
         else check(h_tag_q.pop_front(), {24'd0, host_rdata}, {24'd0, h_exp_q.pop_front()});
      end
   end

   task automatic mwrite(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      mgmt_req = 1; mgmt_we = 1; mgmt_addr = a; mgmt_be = be; mgmt_wdata = d;
      @(negedge clk);
      mgmt_req = 0; mgmt_we = 0;
   endtask

   task automatic mread(input logic [11:0] a, input logic [31:0] exp, input string tag);
      m_exp_q.push_back(exp); m_tag_q.push_back(tag);
      @(negedge clk);
      mgmt_req = 1; mgmt_we = 0; mgmt_addr = a;
      @(negedge clk);
      mgmt_req = 0;
   endtask

   task automatic hwrite(input logic [1:0] ch, input logic st, input logic [7:0] d);
      @(negedge clk);
      host_req = 1; host_we = 1; host_sel_status = st; host_chan = ch; host_wdata = d;
      @(negedge clk);
      host_req = 0; host_we = 0; host_sel_status = 0;
   endtask

   task automatic hread(input logic [1:0] ch, input logic st, input logic [7:0] exp, input string tag);
      h_exp_q.push_back(exp); h_tag_q.push_back(tag);
      @(negedge clk);
      host_req = 1; host_we = 0; host_sel_status = st; host_chan = ch;
      @(negedge clk);
      host_req = 0; host_sel_status = 0;
   endtask

   task automatic finish_sim();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check("watchdog expired", 32'd1, 32'd0);
      finish_sim();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 irq low in reset", {27'd0, irq_any, chan_irq}, 32'd0);
      rst_n = 1;
      // R1 reset state
      mread(12'h088, INIT7, "R1 init word");
      mread(12'h000, 32'd0, "R1 ctl0 zero");
      check("R1 irq after reset", {28'd0, chan_irq}, 32'd0);
      // R2 byte enables
      mwrite(12'h014, 4'hF, 32'h1122_3344);
      mwrite(12'h014, 4'b0010, 32'hFFFF_FFFF);
      mread(12'h014, 32'h1122_FF44, "R2 byte enable");
      // R3 out of range
      mwrite(12'h200, 4'hF, 32'hDEAD_BEEF);
      mread(12'h200, 32'd0, "R3 oob read");
      mread(12'hFFC, 32'd0, "R3 top of window");
      mread(12'h000, 32'd0, "R3 wrapped write ignored");
      // R4 host write with channel off
      hwrite(2'd0, 1'b0, 8'h5A);
      mread(12'h03C, 32'h2, "R4 ibf set");
      check("R6 no irq while off", {28'd0, chan_irq}, 32'd0);
      mread(12'h024, 32'h5A, "R5 idr byte");
      mread(12'h03C, 32'h0, "R5 ibf cleared");
      // R6 enabled channel 0
      mwrite(12'h000, 4'hF, 32'h20);
      mwrite(12'h008, 4'hF, 32'h2);
      hwrite(2'd0, 1'b0, 8'hA5);
      check("R6 irq ch0", {28'd0, chan_irq}, 32'h1);
      check("R10 any with ch0", {31'd0, irq_any}, 32'd1);
      mread(12'h024, 32'hA5, "R5 idr byte ch0");
      check("R5 irq lowered", {28'd0, chan_irq}, 32'h0);
      // R6 interrupt enable without channel enable (ch1)
      mwrite(12'h008, 4'hF, 32'h6);
      hwrite(2'd1, 1'b0, 8'h11);
      check("R6 ie without enable", {28'd0, chan_irq}, 32'h0);
      mread(12'h028, 32'h11, "R5 idr ch1");
      // R7 channel 2 dual enable
      mwrite(12'h000, 4'hF, 32'hA0);
      mwrite(12'h008, 4'hF, 32'hE);
      hwrite(2'd2, 1'b0, 8'h33);
      check("R7 one enable only", {28'd0, chan_irq}, 32'h0);
      mread(12'h02C, 32'h33, "R5 idr ch2");
      mwrite(12'h010, 4'hF, 32'h4);
      hwrite(2'd2, 1'b0, 8'h44);
      check("R7 both enables", {28'd0, chan_irq}, 32'h4);
      // R6 channel 3 high control word
      mwrite(12'h100, 4'hF, 32'h2);
      hwrite(2'd3, 1'b0, 8'h55);
      check("R6 ch3 ie only", {28'd0, chan_irq}, 32'h4);
      mread(12'h114, 32'h55, "R4 ch3 idr");
      mwrite(12'h100, 4'hF, 32'h3);
      hwrite(2'd3, 1'b0, 8'h66);
      check("R6 ch3 enabled", {28'd0, chan_irq}, 32'hC);
      // R10 combined line
      mread(12'h02C, 32'h44, "R5 idr ch2 second");
      check("R10 ch3 still pending", {27'd0, irq_any, chan_irq}, 32'h18);
      mread(12'h114, 32'h66, "R5 idr ch3 second");
      check("R10 all clear", {27'd0, irq_any, chan_irq}, 32'h0);
      // R8 outbound path
      mwrite(12'h034, 4'hF, 32'h77);
      mread(12'h040, 32'h1, "R8 obf set");
      hread(2'd1, 1'b0, 8'h77, "R8 host data read");
      mread(12'h040, 32'h0, "R8 obf cleared");
      // R9 host status write ignored
      mwrite(12'h040, 4'hF, 32'h08);
      hwrite(2'd1, 1'b1, 8'hFF);
      mread(12'h040, 32'h08, "R9 status unchanged");
      hread(2'd1, 1'b1, 8'h08, "R9 host status read");
      repeat (3) @(negedge clk);
      check("R2 all reads answered", m_exp_q.size() + h_exp_q.size(), 32'd0);
      finish_sim();
   end
endmodule